// File: doc/BRIEF.md
# Recent Address Memoization Buffer

This block sits next to a set-associative cache. For each bank it keeps a small, fully associative list of recently resolved accesses. Each entry holds the tag, the set index and the way that held the line. A cache access presents its tag and set index. Every entry of the addressed bank is compared against them in the same cycle. On a match the buffer returns the stored way one cycle later. It also raises a strobe that tells the cache to skip its tag-array read, and drives a one-hot enable so that only that data way is read. On a miss every way stays enabled, the cache runs its normal lookup, and then reports the resolved way back as a fill.

The banks are independent. Typically one serves instruction fetches and one serves data accesses. When the cache replaces a line, it reports the set and way. Any entry that points at that slot is dropped at once, so the buffer never returns a way that now holds a different line. Replacement inside a bank follows least-recently-used order. Both lookup hits and fills count as uses.

Top module: `recent_addr_buffer`

## Requirements
- R1: A lookup hits only when a valid entry in the bank selected by `req_bank` matches both `req_tag` and `req_set`. Entries in other banks never produce a hit.
- R2: `hit`, `tag_lookup_suppress` and `way_id` reflect the request of the previous cycle. On a miss, or when no request was presented, `hit` and `tag_lookup_suppress` are 0 and `way_id` is 0.
- R3: `data_way_en` has exactly bit `way_id` set while `hit` is 1, and all bits set while `hit` is 0.
- R4: A fill records its tag, set and way in the addressed bank, so that a later lookup of that tag and set hits with that way. If an entry already holds that tag and set, its way is overwritten and no second entry is made.
- R5: A fill that needs a new entry takes an invalid entry of the bank if one exists. Otherwise it replaces the least recently used entry.
- R6: A lookup hit and a fill each make their entry the most recently used. When a fill and a lookup address the same bank in one cycle, only the fill updates the recency order.
- R7: An eviction removes, in the same cycle, every entry of its bank whose set and way equal `evict_set` and `evict_way`. A lookup in that cycle that would have hit such an entry reports a miss.
- R8: When an eviction and a fill fall in the same cycle and bank, the eviction is applied first and the fill is then recorded, even if both name the same set and way.
- R9: After reset every entry of every bank is invalid, so every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_bank | input | BANK_W | Bank addressed by the lookup |
| req_tag | input | TAG_W | Tag of the access |
| req_set | input | SET_W | Set index of the access |
| fill_valid | input | 1 | Record a resolved access |
| fill_bank | input | BANK_W | Bank for the fill |
| fill_tag | input | TAG_W | Resolved tag |
| fill_set | input | SET_W | Resolved set index |
| fill_way | input | WAY_W | Way that holds the line |
| evict_valid | input | 1 | Cache replaced a line |
| evict_bank | input | BANK_W | Bank whose cache replaced the line |
| evict_set | input | SET_W | Set of the replaced line |
| evict_way | input | WAY_W | Way of the replaced line |
| hit | output | 1 | Previous request matched a live entry |
| way_id | output | WAY_W | Way recorded for the matching entry |
| tag_lookup_suppress | output | 1 | Cache may skip its tag-array read |
| data_way_en | output | WAYS | Data way enables for the cache |

## Verification
Three pairs of functions can fall in the same cycle: a lookup with an eviction of the slot it would hit, an eviction with a refill of the very same set and way, and a lookup with a fill to the same bank. Each pair is provoked on purpose with directed steps. A long random stream then drives all three ports at once. Every response is compared against a recency-ordered list model in the bench, and the later lookups show whether the right entry was dropped, kept or replaced.

// File: rtl/rab_pkg.sv
package rab_pkg;
   // Which event owns the recency update of a bank in a cycle.
   typedef enum logic [1:0] {
      TOUCH_NONE   = 2'd0,
      TOUCH_LOOKUP = 2'd1,
      TOUCH_FILL   = 2'd2
   } touch_src_e;
endpackage

// File: rtl/rab_cam.sv
// Parallel equality compare of one probe key against every stored key.
module rab_cam #(
   parameter int unsigned N     = 8,
   parameter int unsigned KEY_W = 8
) (
   input  logic [N-1:0]       live_i,
   input  logic [N*KEY_W-1:0] keys_i,
   input  logic [KEY_W-1:0]   probe_i,
   output logic [N-1:0]       match_o
);
   for (genvar i = 0; i < N; i++) begin : g_cmp
      assign match_o[i] = live_i[i] && (keys_i[i*KEY_W +: KEY_W] == probe_i);
   end
endmodule

// File: rtl/rab_lru.sv
// True LRU by per-entry age; ages form a permutation of 0..N-1.
module rab_lru #(
   parameter int unsigned N     = 8,
   parameter int unsigned IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             touch_i,
   input  logic [IDX_W-1:0] touch_idx_i,
   output logic [IDX_W-1:0] oldest_o
);
   logic [IDX_W-1:0] age_q [N];
   logic [IDX_W-1:0] ref_age;

   assign ref_age = age_q[touch_idx_i];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) age_q[i] <= IDX_W'(i);
      end else if (touch_i) begin
         for (int i = 0; i < N; i++) begin
            if (IDX_W'(i) == touch_idx_i)  age_q[i] <= '0;
            else if (age_q[i] < ref_age)   age_q[i] <= age_q[i] + 1'b1;
         end
      end
   end

   always_comb begin
      oldest_o = '0;
      for (int i = 0; i < N; i++)
         if (age_q[i] == IDX_W'(N - 1)) oldest_o = IDX_W'(i);
   end
endmodule

// File: rtl/rab_bank.sv
// One bank: entry storage, three compare planes, victim choice, recency.
module rab_bank
   import rab_pkg::*;
#(
   parameter int unsigned TAG_W = 20,
   parameter int unsigned SET_W = 7,
   parameter int unsigned WAY_W = 2,
   parameter int unsigned N     = 8,
   parameter int unsigned IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lk_req_i,
   input  logic [TAG_W-1:0] lk_tag_i,
   input  logic [SET_W-1:0] lk_set_i,
   input  logic             fill_en_i,
   input  logic [TAG_W-1:0] fill_tag_i,
   input  logic [SET_W-1:0] fill_set_i,
   input  logic [WAY_W-1:0] fill_way_i,
   input  logic             ev_en_i,
   input  logic [SET_W-1:0] ev_set_i,
   input  logic [WAY_W-1:0] ev_way_i,
   output logic             lk_hit_o,
   output logic [WAY_W-1:0] lk_way_o
);
   localparam int unsigned KEY_W = TAG_W + SET_W;
   localparam int unsigned LOC_W = SET_W + WAY_W;

   logic [N-1:0]       valid_q;
   logic [N*KEY_W-1:0] key_q;     // {tag, set} per entry
   logic [N*WAY_W-1:0] way_q;
   logic [N*LOC_W-1:0] loc;       // {set, way} per entry

   logic [N-1:0] lk_match, ev_match, fill_match;
   logic [N-1:0] kill, survive, lk_live;
   logic [IDX_W-1:0] lk_idx, fill_idx, oldest_idx, touch_idx;
   touch_src_e touch_src;

   for (genvar i = 0; i < N; i++) begin : g_loc
      assign loc[i*LOC_W +: LOC_W] = {key_q[i*KEY_W +: SET_W], way_q[i*WAY_W +: WAY_W]};
   end

   rab_cam #(.N(N), .KEY_W(KEY_W)) u_lk_cam (
      .live_i(valid_q), .keys_i(key_q), .probe_i({lk_tag_i, lk_set_i}), .match_o(lk_match));

   rab_cam #(.N(N), .KEY_W(LOC_W)) u_ev_cam (
      .live_i(valid_q), .keys_i(loc), .probe_i({ev_set_i, ev_way_i}), .match_o(ev_match));

   assign kill    = ev_match & {N{ev_en_i}};
   assign survive = valid_q & ~kill;
   assign lk_live = lk_match & ~kill;

   rab_cam #(.N(N), .KEY_W(KEY_W)) u_fill_cam (
      .live_i(survive), .keys_i(key_q), .probe_i({fill_tag_i, fill_set_i}), .match_o(fill_match));

   always_comb begin
      lk_way_o = '0;
      lk_idx   = '0;
      for (int i = 0; i < N; i++) begin
         if (lk_live[i]) begin
            lk_way_o = lk_way_o | way_q[i*WAY_W +: WAY_W];
            lk_idx   = lk_idx | IDX_W'(i);
         end
      end
   end
   assign lk_hit_o = |lk_live;

   always_comb begin
      fill_idx = oldest_idx;
      if (|fill_match) begin
         for (int i = 0; i < N; i++)
            if (fill_match[i]) fill_idx = IDX_W'(i);
      end else if (|(~survive)) begin
         for (int i = int'(N) - 1; i >= 0; i--)
            if (!survive[i]) fill_idx = IDX_W'(i);
      end
   end

   always_comb begin
      if (fill_en_i)                 touch_src = TOUCH_FILL;
      else if (lk_req_i && lk_hit_o) touch_src = TOUCH_LOOKUP;
      else                           touch_src = TOUCH_NONE;
   end
   assign touch_idx = (touch_src == TOUCH_FILL) ? fill_idx : lk_idx;

   rab_lru #(.N(N), .IDX_W(IDX_W)) u_lru (
      .clk(clk), .rst_n(rst_n), .touch_i(touch_src != TOUCH_NONE),
      .touch_idx_i(touch_idx), .oldest_o(oldest_idx));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         key_q   <= '0;
         way_q   <= '0;
      end else begin
         valid_q <= survive;
         if (fill_en_i) begin
            valid_q[fill_idx]                  <= 1'b1;
            key_q[fill_idx*KEY_W +: KEY_W]     <= {fill_tag_i, fill_set_i};
            way_q[fill_idx*WAY_W +: WAY_W]     <= fill_way_i;
         end
      end
   end
endmodule

// File: rtl/recent_addr_buffer.sv
module recent_addr_buffer #(
   parameter int unsigned TAG_W   = 20,
   parameter int unsigned SET_W   = 7,
   parameter int unsigned WAYS    = 4,
   parameter int unsigned ENTRIES = 8,
   parameter int unsigned BANKS   = 2,
   localparam int unsigned WAY_W  = $clog2(WAYS),
   localparam int unsigned BANK_W = $clog2(BANKS),
   localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [BANK_W-1:0] req_bank,
   input  logic [TAG_W-1:0]  req_tag,
   input  logic [SET_W-1:0]  req_set,
   input  logic              fill_valid,
   input  logic [BANK_W-1:0] fill_bank,
   input  logic [TAG_W-1:0]  fill_tag,
   input  logic [SET_W-1:0]  fill_set,
   input  logic [WAY_W-1:0]  fill_way,
   input  logic              evict_valid,
   input  logic [BANK_W-1:0] evict_bank,
   input  logic [SET_W-1:0]  evict_set,
   input  logic [WAY_W-1:0]  evict_way,
   output logic              hit,
   output logic [WAY_W-1:0]  way_id,
   output logic              tag_lookup_suppress,
   output logic [WAYS-1:0]   data_way_en
);
   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("ENTRIES must be a power of two and at least 2");
   end
   if (BANKS < 2) begin : g_bad_banks
      $error("BANKS must be at least 2");
   end
   if (WAYS < 2) begin : g_bad_ways
      $error("WAYS must be at least 2");
   end
   if (TAG_W < 1 || SET_W < 1) begin : g_bad_key
      $error("TAG_W and SET_W must be at least 1");
   end

   logic [BANKS-1:0] bank_hit;
   logic [WAY_W-1:0] bank_way [BANKS];
   logic             sel_hit;
   logic [WAY_W-1:0] sel_way;
   logic             hit_q;
   logic [WAY_W-1:0] way_q;

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      rab_bank #(
         .TAG_W(TAG_W), .SET_W(SET_W), .WAY_W(WAY_W), .N(ENTRIES), .IDX_W(IDX_W)
      ) u_bank (
         .clk        (clk),
         .rst_n      (rst_n),
         .lk_req_i   (req_valid && (req_bank == BANK_W'(b))),
         .lk_tag_i   (req_tag),
         .lk_set_i   (req_set),
         .fill_en_i  (fill_valid && (fill_bank == BANK_W'(b))),
         .fill_tag_i (fill_tag),
         .fill_set_i (fill_set),
         .fill_way_i (fill_way),
         .ev_en_i    (evict_valid && (evict_bank == BANK_W'(b))),
         .ev_set_i   (evict_set),
         .ev_way_i   (evict_way),
         .lk_hit_o   (bank_hit[b]),
         .lk_way_o   (bank_way[b])
      );
   end

   always_comb begin
      sel_hit = 1'b0;
      sel_way = '0;
      for (int b = 0; b < BANKS; b++) begin
         if (req_valid && req_bank == BANK_W'(b)) begin
            sel_hit = bank_hit[b];
            sel_way = bank_way[b];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_q <= 1'b0;
         way_q <= '0;
      end else begin
         hit_q <= sel_hit;
         way_q <= sel_hit ? sel_way : '0;
      end
   end

   assign hit                 = hit_q;
   assign tag_lookup_suppress = hit_q;
   assign way_id              = way_q;
   assign data_way_en         = hit_q ? (WAYS'(1) << way_q) : '1;
endmodule

// File: rtl/rab_checker.sv
module rab_checker #(
   parameter int unsigned TAG_W  = 20,
   parameter int unsigned SET_W  = 7,
   parameter int unsigned WAYS   = 4,
   parameter int unsigned WAY_W  = 2,
   parameter int unsigned BANK_W = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [BANK_W-1:0] req_bank,
   input logic [TAG_W-1:0]  req_tag,
   input logic [SET_W-1:0]  req_set,
   input logic              fill_valid,
   input logic [BANK_W-1:0] fill_bank,
   input logic [TAG_W-1:0]  fill_tag,
   input logic [SET_W-1:0]  fill_set,
   input logic [WAY_W-1:0]  fill_way,
   input logic              evict_valid,
   input logic [BANK_W-1:0] evict_bank,
   input logic [SET_W-1:0]  evict_set,
   input logic [WAY_W-1:0]  evict_way,
   input logic              hit,
   input logic [WAY_W-1:0]  way_id,
   input logic              tag_lookup_suppress,
   input logic [WAYS-1:0]   data_way_en
);
   a_r3_single_way_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> ($countones(data_way_en) == 1 && data_way_en[way_id]));

   a_r3_all_ways_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (&data_way_en));

   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!hit && !tag_lookup_suppress && way_id == '0));

   a_r7_evict_blocks_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && evict_valid && req_bank == evict_bank && req_set == evict_set)
      |=> !(hit && way_id == $past(evict_way)));

   a_r4_fill_then_hit: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(fill_valid) && req_valid && !evict_valid &&
       req_bank == $past(fill_bank) && req_tag == $past(fill_tag) && req_set == $past(fill_set))
      |=> (hit && tag_lookup_suppress && way_id == $past(fill_way, 2)));
endmodule

bind recent_addr_buffer rab_checker #(
   .TAG_W(TAG_W), .SET_W(SET_W), .WAYS(WAYS), .WAY_W(WAY_W), .BANK_W(BANK_W)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .req_valid(req_valid), .req_bank(req_bank), .req_tag(req_tag), .req_set(req_set),
   .fill_valid(fill_valid), .fill_bank(fill_bank), .fill_tag(fill_tag),
   .fill_set(fill_set), .fill_way(fill_way),
   .evict_valid(evict_valid), .evict_bank(evict_bank), .evict_set(evict_set),
   .evict_way(evict_way),
   .hit(hit), .way_id(way_id), .tag_lookup_suppress(tag_lookup_suppress),
   .data_way_en(data_way_en)
);

// File: tb/sim_recent_addr_buffer.sv
module sim_recent_addr_buffer;
   localparam int TW = 3, SW = 2, NW = 4, NE = 4, NB = 2;
   localparam int WW = 2, BW = 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic          req_valid = 0, fill_valid = 0, evict_valid = 0;
   logic [BW-1:0] req_bank = 0, fill_bank = 0, evict_bank = 0;
   logic [TW-1:0] req_tag = 0, fill_tag = 0;
   logic [SW-1:0] req_set = 0, fill_set = 0, evict_set = 0;
   logic [WW-1:0] fill_way = 0, evict_way = 0;
   logic          hit, tag_lookup_suppress;
   logic [WW-1:0] way_id;
   logic [NW-1:0] data_way_en;

   recent_addr_buffer #(.TAG_W(TW), .SET_W(SW), .WAYS(NW), .ENTRIES(NE), .BANKS(NB)) u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_bank(req_bank), .req_tag(req_tag), .req_set(req_set),
      .fill_valid(fill_valid), .fill_bank(fill_bank), .fill_tag(fill_tag),
      .fill_set(fill_set), .fill_way(fill_way),
      .evict_valid(evict_valid), .evict_bank(evict_bank), .evict_set(evict_set),
      .evict_way(evict_way),
      .hit(hit), .way_id(way_id), .tag_lookup_suppress(tag_lookup_suppress),
      .data_way_en(data_way_en));

   always #5ns clk = ~clk;

   int checks = 0, fails = 0;
   bit done = 0;

   // Reference: per bank a list ordered from most to least recently used.
   int mcnt [NB];
   int mt [NB][NE];
   int ms [NB][NE];
   int mw [NB][NE];

   function automatic int mfind(int b, int t, int s);
      for (int i = 0; i < mcnt[b]; i++)
         if (mt[b][i] == t && ms[b][i] == s) return i;
      return -1;
   endfunction

   function automatic void mdrop(int b, int p);
      for (int i = p; i < mcnt[b] - 1; i++) begin
         mt[b][i] = mt[b][i+1]; ms[b][i] = ms[b][i+1]; mw[b][i] = mw[b][i+1];
      end
      mcnt[b]--;
   endfunction

   function automatic void mfront(int b, int t, int s, int w);
      if (mcnt[b] == NE) mcnt[b]--;
      for (int i = mcnt[b]; i > 0; i--) begin
         mt[b][i] = mt[b][i-1]; ms[b][i] = ms[b][i-1]; mw[b][i] = mw[b][i-1];
      end
      mt[b][0] = t; ms[b][0] = s; mw[b][0] = w;
      mcnt[b]++;
   endfunction

   task automatic step(string tag, int rq, int rb, int rt, int rs,
                       int fv, int fb, int ft, int fs, int fw,
                       int ev, int eb, int es, int ew);
      int p, q, ew_hit, exp_way, t0, s0, w0;
      logic [NW-1:0] exp_en;
      req_valid = rq[0]; req_bank = BW'(rb); req_tag = TW'(rt); req_set = SW'(rs);
      fill_valid = fv[0]; fill_bank = BW'(fb); fill_tag = TW'(ft); fill_set = SW'(fs);
      fill_way = WW'(fw);
      evict_valid = ev[0]; evict_bank = BW'(eb); evict_set = SW'(es); evict_way = WW'(ew);
      p = (rq != 0) ? mfind(rb, rt, rs) : -1;
      ew_hit = 0;
      if (p >= 0) ew_hit = !(ev != 0 && eb == rb && es == rs && mw[rb][p] == ew);
      exp_way = ew_hit ? mw[rb][p] : 0;
      @(posedge clk);
      if (ew_hit != 0 && !(fv != 0 && fb == rb)) begin
         t0 = mt[rb][p]; s0 = ms[rb][p]; w0 = mw[rb][p];
         mdrop(rb, p); mfront(rb, t0, s0, w0);
      end
      if (ev != 0)
         for (int i = mcnt[eb] - 1; i >= 0; i--)
            if (ms[eb][i] == es && mw[eb][i] == ew) mdrop(eb, i);
      if (fv != 0) begin
         q = mfind(fb, ft, fs);
         if (q >= 0) mdrop(fb, q);
         mfront(fb, ft, fs, fw);
      end
      @(negedge clk);
      req_valid = 0; fill_valid = 0; evict_valid = 0;
      exp_en = (ew_hit != 0) ? (NW'(1) << exp_way) : '1;
      checks++;
      if (hit !== ew_hit[0] || tag_lookup_suppress !== ew_hit[0] ||
          way_id !== WW'(exp_way) || data_way_en !== exp_en) begin
         fails++;
         $display("FAIL %s: hit=%b sup=%b way=%0d en=%b expected hit=%0d way=%0d en=%b",
                  tag, hit, tag_lookup_suppress, way_id, data_way_en, ew_hit, exp_way, exp_en);
      end
   endtask

   task automatic look(string tag, int b, int t, int s);
      step(tag, 1, b, t, s, 0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic fill(string tag, int b, int t, int s, int w);
      step(tag, 0, 0, 0, 0, 1, b, t, s, w, 0, 0, 0, 0);
   endtask

   task automatic sweep(string tag);
      for (int b = 0; b < NB; b++)
         for (int t = 0; t < (1 << TW); t++)
            for (int s = 0; s < (1 << SW); s++)
               look(tag, b, t, s);
   endtask

   initial begin
      #1ms;
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int b = 0; b < NB; b++) mcnt[b] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R9 and R2: empty after reset, idle cycle quiet
      step("R2", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      sweep("R9");
      // R1 / R4: fill bank 0, sweep both banks
      for (int i = 0; i < NE; i++) fill("R4", 0, i, i, 3 - i);
      sweep("R1");
      // R5: bank full, next fills replace least recently used entries
      look("R6", 0, 1, 1);
      fill("R5", 0, 7, 2, 1);
      fill("R5", 0, 6, 3, 2);
      sweep("R5");
      // R4: duplicate fill rewrites way
      fill("R4", 0, 7, 2, 3);
      look("R4", 0, 7, 2);
      // R6: fill and lookup same bank same cycle, then new fills
      step("R6", 1, 0, 6, 3, 1, 0, 5, 0, 0, 0, 0, 0, 0);
      fill("R6", 0, 4, 1, 1);
      sweep("R6");
      // R7: lookup with eviction of its slot, and of another way
      step("R7", 1, 0, 7, 2, 0, 0, 0, 0, 0, 1, 0, 2, 3);
      look("R7", 0, 7, 2);
      step("R7", 1, 0, 5, 0, 0, 0, 0, 0, 0, 1, 0, 0, 3);
      step("R7", 1, 0, 5, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0);
      look("R7", 0, 5, 0);
      // R8: eviction and refill of the same slot in one cycle
      fill("R8", 1, 2, 2, 2);
      step("R8", 0, 0, 0, 0, 1, 1, 3, 2, 2, 1, 1, 2, 2);
      look("R8", 1, 3, 2);
      look("R8", 1, 2, 2);
      // Random mix of all three ports
      for (int n = 0; n < 3000; n++) begin
         int r;
         r = int'($urandom);
         step("R6", r & 1, (r >> 1) & 1, (r >> 2) & 7, (r >> 5) & 3,
              ((r >> 7) & 3) == 0, (r >> 9) & 1, (r >> 10) & 7, (r >> 13) & 3, (r >> 15) & 3,
              ((r >> 17) & 7) == 0, (r >> 20) & 1, (r >> 21) & 3, (r >> 23) & 3);
      end
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule